// File: doc/BRIEF.md
# Timing Tick and Interrupt Controller

This block keeps sub-second time for an instrument processor and turns that time into interrupts. It counts microsecond events into a subsecond counter, which other logic can sample as a timestamp. A once-per-second pulse clears the counter. The timing events come from one of two places:

- an external microsecond strobe and an external second pulse, both asynchronous to the system clock; or
- an internal divider running from the system clock, selected by a control bit.

The block has three interrupt sources:

- a timer interrupt at a programmable rate;
- a one-second interrupt;
- an interrupt on the falling edge of a DMA end-of-process input.

Each source sets a sticky status bit, and the interrupt outputs follow those bits. The processor clears any subset of the bits with one write strobe and a bit mask. The timer interrupt is never raised on the tick that coincides with the second. So at the slowest rate the processor sees seven timer interrupts and one second interrupt each second.

Top module: `tick_irq_ctrl`

## Requirements
- R1: Each rising edge of `us_strobe_i` advances `sub_count_o` by exactly one. The edge is taken after a two-flop synchronizer and an edge detector. The counter wraps modulo 2^SUB_W.
- R2: A rising edge of `sec_pulse_i` clears `sub_count_o` to zero. The clear wins over a microsecond advance in the same cycle.
- R3: A timer event is raised when the counter advances to a nonzero value that is a multiple of 2^(SUB_W-3-rate), where rate is `ctrl_rate_i`. A second spans 2^SUB_W microsecond events, so the interrupt rate is 8·2^rate Hz. Rate 0 gives 8 Hz, which is the rate seen with the control input at zero.
- R4: No timer event is raised by the event that brings the counter to zero, whether that is a second pulse or a wrap. Per second this gives 8·2^rate − 1 timer interrupts: 7 at rate 0, 63 at rate 3 and 1023 at rate 7.
- R5: Each second event sets status bit 1, the one-second interrupt.
- R6: A falling edge of `dma_eop_i` sets status bit 2. A rising edge does not.
- R7: The status bits are bit 0 for the timer, bit 1 for the second and bit 2 for DMA. A set bit holds until a cycle with `clr_wr_i` high and the matching bit of `clr_mask_i` at 1. Clearing one bit leaves the others unchanged. `irq_timer_o`, `irq_sec_o` and `irq_dma_o` equal status bits 0, 1 and 2.
- R8: If a clear and a new event for the same bit occur in the same cycle, the bit stays set.
- R9: With `ctrl_int_i` high, a microsecond event is made every CLK_DIV system clocks and a second event every US_PER_SEC microsecond events. In this mode the external strobe and pulse inputs have no effect.
- R10: After reset the status bits, the interrupt outputs and `sub_count_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ctrl_rate_i | input | RATE_W | Timer interrupt rate select |
| ctrl_int_i | input | 1 | 1 selects the internal timebase |
| us_strobe_i | input | 1 | External microsecond strobe, asynchronous |
| sec_pulse_i | input | 1 | External one-second pulse, asynchronous |
| dma_eop_i | input | 1 | DMA end-of-process, asynchronous, falling edge active |
| clr_wr_i | input | 1 | Clear strobe for the status bits |
| clr_mask_i | input | 3 | Status bits to clear when `clr_wr_i` is high |
| sub_count_o | output | SUB_W | Subsecond count |
| status_o | output | 3 | Latched interrupt status |
| irq_timer_o | output | 1 | Timer interrupt |
| irq_sec_o | output | 1 | One-second interrupt |
| irq_dma_o | output | 1 | DMA interrupt |

## Verification
The assertions assume that each asynchronous input holds a level for at least two system clocks, so that the synchronizer sees every edge. They also assume that the external strobes idle low, so that no edge is seen just after reset. The stimulus keeps every strobe level for three or four clocks and parks both strobe inputs low. It changes the rate select only between measured seconds, and never while a second is being counted. The one exactly timed stimulus is the clear that must land in the same cycle as a DMA set. It is placed by counting the synchronizer, edge and latch registers from the input change.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
  localparam int IRQ_N     = 3;
  localparam int IRQ_TIMER = 0;
  localparam int IRQ_SEC   = 1;
  localparam int IRQ_DMA   = 2;
  typedef logic [IRQ_N-1:0] irq_vec_t;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;
endpackage

// File: rtl/tick_sync_edge.sv
module tick_sync_edge
  import tick_irq_pkg::*;
#(
  parameter int         STAGES = 2,
  parameter edge_kind_e KIND   = EDGE_RISE
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic evt_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;
  logic              hit;

  generate
    if (KIND == EDGE_RISE) begin : g_rise
      assign hit = chain_q[STAGES-1] & ~last_q;
    end else begin : g_fall
      assign hit = ~chain_q[STAGES-1] & last_q;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      chain_q <= '0;
      last_q  <= 1'b0;
      evt_o   <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      last_q  <= chain_q[STAGES-1];
      evt_o   <= hit;
    end
  end
endmodule

// File: rtl/tick_int_base.sv
module tick_int_base #(
  parameter int CLK_DIV    = 10,
  parameter int US_PER_SEC = 1_000_000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic us_o,
  output logic sec_o
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int US_W  = (US_PER_SEC > 1) ? $clog2(US_PER_SEC) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [US_W-1:0]  US_LAST  = US_W'(US_PER_SEC - 1);

  logic [DIV_W-1:0] div_q;
  logic [US_W-1:0]  us_cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      div_q    <= '0;
      us_cnt_q <= '0;
      us_o     <= 1'b0;
      sec_o    <= 1'b0;
    end else begin
      us_o  <= 1'b0;
      sec_o <= 1'b0;
      if (div_q == DIV_LAST) begin
        div_q <= '0;
        us_o  <= 1'b1;
        if (us_cnt_q == US_LAST) begin
          us_cnt_q <= '0;
          sec_o    <= 1'b1;
        end else begin
          us_cnt_q <= us_cnt_q + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tick_subsec.sv
module tick_subsec #(
  parameter int SUB_W  = 20,
  parameter int RATE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              us_evt_i,
  input  logic              sec_evt_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [SUB_W-1:0]  count_o,
  output logic              timer_o,
  output logic              sec_o
);
  localparam int BASE_SHIFT = SUB_W - 3;
  localparam int SHW        = $clog2(SUB_W + 1);

  logic [SHW-1:0]   shamt;
  logic [SUB_W-1:0] low_mask;
  logic [SUB_W-1:0] nxt;
  logic             on_grid;

  always_comb begin
    shamt    = SHW'(BASE_SHIFT) - SHW'(rate_i);
    low_mask = ~({SUB_W{1'b1}} << shamt);
    nxt      = count_o + 1'b1;
    on_grid  = ((nxt & low_mask) == '0) && (nxt != '0);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      count_o <= '0;
      timer_o <= 1'b0;
      sec_o   <= 1'b0;
    end else begin
      timer_o <= 1'b0;
      sec_o   <= sec_evt_i;
      if (sec_evt_i) begin
        count_o <= '0;
      end else if (us_evt_i) begin
        count_o <= nxt;
        timer_o <= on_grid;
      end
    end
  end
endmodule

// File: rtl/tick_irq_latch.sv
module tick_irq_latch
  import tick_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  irq_vec_t set_i,
  input  logic     clr_wr_i,
  input  irq_vec_t clr_mask_i,
  output irq_vec_t status_o
);
  generate
    for (genvar i = 0; i < IRQ_N; i++) begin : g_bit
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          status_o[i] <= 1'b0;
        end else begin
          status_o[i] <= set_i[i] | (status_o[i] & ~(clr_wr_i & clr_mask_i[i]));
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl
  import tick_irq_pkg::*;
#(
  parameter int SUB_W       = 20,
  parameter int RATE_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int CLK_DIV     = 10,
  parameter int US_PER_SEC  = 1_000_000
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [RATE_W-1:0] ctrl_rate_i,
  input  logic              ctrl_int_i,
  input  logic              us_strobe_i,
  input  logic              sec_pulse_i,
  input  logic              dma_eop_i,
  input  logic              clr_wr_i,
  input  logic [2:0]        clr_mask_i,
  output logic [SUB_W-1:0]  sub_count_o,
  output logic [2:0]        status_o,
  output logic              irq_timer_o,
  output logic              irq_sec_o,
  output logic              irq_dma_o
);
  logic     ext_us, ext_sec, dma_fall;
  logic     int_us, int_sec;
  logic     us_evt, sec_evt;
  logic     timer_q, sec_q;
  irq_vec_t set_vec;
  irq_vec_t stat;

  tick_sync_edge #(.STAGES(SYNC_STAGES), .KIND(EDGE_RISE)) u_us_sync (
    .clk_i(clk_i), .rst_i(rst_i), .async_i(us_strobe_i), .evt_o(ext_us));
  tick_sync_edge #(.STAGES(SYNC_STAGES), .KIND(EDGE_RISE)) u_sec_sync (
    .clk_i(clk_i), .rst_i(rst_i), .async_i(sec_pulse_i), .evt_o(ext_sec));
  tick_sync_edge #(.STAGES(SYNC_STAGES), .KIND(EDGE_FALL)) u_dma_sync (
    .clk_i(clk_i), .rst_i(rst_i), .async_i(dma_eop_i), .evt_o(dma_fall));

  tick_int_base #(.CLK_DIV(CLK_DIV), .US_PER_SEC(US_PER_SEC)) u_base (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(ctrl_int_i),
    .us_o(int_us), .sec_o(int_sec));

  assign us_evt  = ctrl_int_i ? int_us  : ext_us;
  assign sec_evt = ctrl_int_i ? int_sec : ext_sec;

  tick_subsec #(.SUB_W(SUB_W), .RATE_W(RATE_W)) u_sub (
    .clk_i(clk_i), .rst_i(rst_i), .us_evt_i(us_evt), .sec_evt_i(sec_evt),
    .rate_i(ctrl_rate_i), .count_o(sub_count_o), .timer_o(timer_q),
    .sec_o(sec_q));

  always_comb begin
    set_vec            = '0;
    set_vec[IRQ_TIMER] = timer_q;
    set_vec[IRQ_SEC]   = sec_q;
    set_vec[IRQ_DMA]   = dma_fall;
  end

  tick_irq_latch u_latch (
    .clk_i(clk_i), .rst_i(rst_i), .set_i(set_vec), .clr_wr_i(clr_wr_i),
    .clr_mask_i(clr_mask_i), .status_o(stat));

  assign status_o    = stat;
  assign irq_timer_o = stat[IRQ_TIMER];
  assign irq_sec_o   = stat[IRQ_SEC];
  assign irq_dma_o   = stat[IRQ_DMA];
endmodule

// File: rtl/tick_irq_ctrl_chk.sv
module tick_irq_ctrl_chk #(
  parameter int SUB_W = 20
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             us_evt,
  input logic             sec_evt,
  input logic             timer_q,
  input logic [2:0]       set_vec,
  input logic             clr_wr_i,
  input logic [2:0]       clr_mask_i,
  input logic [SUB_W-1:0] sub_count_o,
  input logic [2:0]       status_o
);
  a_r1_advance: assert property (@(posedge clk_i) disable iff (rst_i)
    (us_evt && !sec_evt) |=> (sub_count_o == $past(sub_count_o) + 1'b1));

  a_r2_sec_clears: assert property (@(posedge clk_i) disable iff (rst_i)
    sec_evt |=> (sub_count_o == '0));

  a_r4_no_timer_on_sec: assert property (@(posedge clk_i) disable iff (rst_i)
    sec_evt |=> !timer_q);

  a_r8_set_wins_timer: assert property (@(posedge clk_i) disable iff (rst_i)
    set_vec[0] |=> status_o[0]);
  a_r8_set_wins_sec: assert property (@(posedge clk_i) disable iff (rst_i)
    set_vec[1] |=> status_o[1]);
  a_r8_set_wins_dma: assert property (@(posedge clk_i) disable iff (rst_i)
    set_vec[2] |=> status_o[2]);

  a_r7_hold_timer: assert property (@(posedge clk_i) disable iff (rst_i)
    (status_o[0] && !(clr_wr_i && clr_mask_i[0])) |=> status_o[0]);
  a_r7_hold_dma: assert property (@(posedge clk_i) disable iff (rst_i)
    (status_o[2] && !(clr_wr_i && clr_mask_i[2])) |=> status_o[2]);

  a_r7_clear_sec: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_wr_i && clr_mask_i[1] && !set_vec[1]) |=> !status_o[1]);
endmodule

bind tick_irq_ctrl tick_irq_ctrl_chk #(.SUB_W(SUB_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .us_evt(us_evt), .sec_evt(sec_evt),
  .timer_q(timer_q), .set_vec(set_vec), .clr_wr_i(clr_wr_i),
  .clr_mask_i(clr_mask_i), .sub_count_o(sub_count_o), .status_o(status_o));

// File: tb/tick_irq_ctrl_bench.sv
module tick_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SUB_W      = 10;
  localparam int RATE_W     = 3;
  localparam int CLK_DIV    = 10;
  localparam int US_PER_SEC = 1000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [RATE_W-1:0] rate = '0;
  logic              int_mode = 1'b0;
  logic              us_s = 1'b0;
  logic              sec_p = 1'b0;
  logic              dma = 1'b1;
  logic              clr_wr = 1'b0;
  logic [2:0]        clr_mask = '0;
  logic [SUB_W-1:0]  sub_count;
  logic [2:0]        status;
  logic              irq_t, irq_s, irq_d;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_irq_ctrl #(
    .SUB_W(SUB_W), .RATE_W(RATE_W), .SYNC_STAGES(2),
    .CLK_DIV(CLK_DIV), .US_PER_SEC(US_PER_SEC)
  ) u_tick_irq_ctrl (
    .clk_i(clk), .rst_i(rst), .ctrl_rate_i(rate), .ctrl_int_i(int_mode),
    .us_strobe_i(us_s), .sec_pulse_i(sec_p), .dma_eop_i(dma),
    .clr_wr_i(clr_wr), .clr_mask_i(clr_mask), .sub_count_o(sub_count),
    .status_o(status), .irq_timer_o(irq_t), .irq_sec_o(irq_s),
    .irq_dma_o(irq_d));

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_us();
    us_s = 1'b1; step(3); us_s = 1'b0; step(4);
  endtask

  task automatic pulse_sec();
    sec_p = 1'b1; step(3); sec_p = 1'b0; step(4);
  endtask

  task automatic clear(input logic [2:0] m);
    clr_mask = m; clr_wr = 1'b1; step(1); clr_wr = 1'b0; clr_mask = '0; step(1);
  endtask

  task automatic t_reset();
    rst = 1'b1; step(4); rst = 1'b0; step(2);
    check(status == 3'b000, "R10 status", int'(status), 0);
    check(sub_count == '0, "R10 count", int'(sub_count), 0);
    check({irq_t, irq_s, irq_d} == 3'b000, "R10 irq", int'({irq_t, irq_s, irq_d}), 0);
  endtask

  task automatic t_count();
    rate = 3'd0;
    pulse_sec(); clear(3'b111);
    check(sub_count == '0, "R2 cleared", int'(sub_count), 0);
    for (int i = 0; i < 5; i++) pulse_us();
    check(sub_count == 5, "R1 advance", int'(sub_count), 5);
    pulse_sec();
    check(sub_count == '0, "R2 second clears", int'(sub_count), 0);
    check(irq_s == 1'b1, "R5 second irq", int'(irq_s), 1);
  endtask

  task automatic t_rate(input int k);
    int n = 0;
    rate = RATE_W'(k);
    pulse_sec(); clear(3'b111);
    for (int i = 0; i < (1 << SUB_W); i++) begin
      pulse_us();
      if (irq_t) begin n++; clear(3'b001); end
    end
    pulse_sec();
    check(irq_t == 1'b0, "R4 no timer at second", int'(irq_t), 0);
    check(irq_s == 1'b1, "R5 second irq", int'(irq_s), 1);
    check(n == (8 << k) - 1, "R3 timer count per second", n, (8 << k) - 1);
  endtask

  task automatic t_dma();
    rate = 3'd0;
    dma = 1'b1; step(6); clear(3'b111);
    dma = 1'b0; step(6);
    check(status[2] == 1'b1, "R6 falling edge", int'(status[2]), 1);
    clear(3'b100);
    dma = 1'b1; step(6);
    check(status[2] == 1'b0, "R6 rising ignored", int'(status[2]), 0);
    pulse_sec();
    dma = 1'b0; step(6);
    clear(3'b010);
    check(status == 3'b100, "R7 selective clear", int'(status), 4);
    check(irq_s == 1'b0 && irq_d == 1'b1, "R7 irq outputs", int'({irq_s, irq_d}), 1);
  endtask

  task automatic t_set_wins();
    dma = 1'b1; step(6); clear(3'b111);
    dma = 1'b0;
    @(posedge clk); @(posedge clk); @(posedge clk);
    @(negedge clk); clr_mask = 3'b100; clr_wr = 1'b1;
    @(posedge clk);
    @(negedge clk); clr_wr = 1'b0; clr_mask = '0;
    check(status[2] == 1'b1, "R8 set beats clear", int'(status[2]), 1);
    step(2);
    check(status[2] == 1'b1, "R8 stays set", int'(status[2]), 1);
  endtask

  task automatic t_internal();
    int n = 0;
    int cyc = 0;
    bit seen = 0;
    rate = 3'd0;
    int_mode = 1'b1; step(2); clear(3'b111);
    pulse_sec();
    check(status[1] == 1'b0, "R9 external pulse ignored", int'(status[1]), 0);
    for (int i = 0; i < 30000 && !seen; i++) begin
      step(1);
      if (irq_s) seen = 1;
    end
    check(seen, "R9 first internal second", int'(seen), 1);
    clear(3'b111);
    seen = 0;
    cyc = 2;
    for (int i = 0; i < 30000 && !seen; i++) begin
      if (irq_s) seen = 1;
      else if (irq_t) begin n++; clear(3'b001); cyc += 2; end
      else begin step(1); cyc++; end
    end
    check(n == 7, "R9 internal timer count", n, 7);
    check(cyc >= CLK_DIV*US_PER_SEC - 10 && cyc <= CLK_DIV*US_PER_SEC + 10,
          "R9 internal second length", cyc, CLK_DIV*US_PER_SEC);
    int_mode = 1'b0; step(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    step(1);
    t_reset();
    t_count();
    t_rate(0);
    t_rate(3);
    t_rate(7);
    t_dma();
    t_set_wins();
    t_internal();
    summary();
    $finish;
  end
endmodule